// File: doc/BRIEF.md
# Dual-Rail Line Alarm Monitor

This block sits on the receive side of a pseudo-ternary line interface and produces two alarms. It samples two active-low rail inputs on every rising edge of the decoder clock. A clock period in which either rail is low carries a mark, and one in which both rails are high carries a space. When a long unbroken run of spaces arrives, the block raises a loss-of-input flag one clock after the run reaches its limit. It drops that flag one clock after the next mark.

The second alarm watches the decoded NRZ bit, which arrives already aligned to the decoder clock. An external active-low window control marks out a counting period. While the control is high, the block counts decoded zeros, saturating at the threshold. On the first clock edge where the control is seen low, the AIS flag is loaded: it is set when fewer zeros than the threshold were counted and cleared otherwise. It then holds that value until the end of the next window. While the control stays low, the zero counter is held cleared.

Top module: `line_alarm_mon`

## Requirements
- R1: A clock period is a mark when `rail_a_n` is 0 or `rail_b_n` is 0. It is a space only when both are 1.
- R2: After LOS_RUN (default 11) consecutive spaces sampled on edges 1..LOS_RUN, `los_flag` is 0 after edge LOS_RUN and 1 after edge LOS_RUN+1. A run of LOS_RUN-1 spaces followed by a mark never sets it.
- R3: A mark sampled on edge k clears the space run. `los_flag` is 0 after edge k+1, one clock later than the mark.
- R4: `los_flag` stays 1 for as long as spaces continue, however long the run.
- R5: The zero counter counts `nrz_bit`==0 only on edges where `win_n` is 1. Zeros seen while `win_n` is 0 are not counted, and the counter is held cleared on those edges.
- R6: On the first edge where `win_n` is 0 after an edge where it was 1, `ais_flag` becomes 1 if fewer than AIS_MIN (default 3) zeros were counted in that high period, and 0 otherwise.
- R7: On every other edge `ais_flag` keeps its value, through the rest of the low period and the whole next high period.
- R8: The zero counter saturates at AIS_MIN, so a window with many zeros (for example 20) still clears `ais_flag`.
- R9: While `rst` is 1 at an edge, both counters clear and `los_flag` and `ais_flag` read 0 after that edge. The first low period after reset does not update AIS unless a high period preceded it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Decoder clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| rail_a_n | input | 1 | First line rail, active low |
| rail_b_n | input | 1 | Second line rail, active low |
| nrz_bit | input | 1 | Decoded NRZ data bit |
| win_n | input | 1 | Zero-count window control; 1 counts, 0 ends and holds the window |
| los_flag | output | 1 | Loss-of-input alarm |
| ais_flag | output | 1 | AIS alarm |

## Verification
The rise of the loss-of-input flag and the AIS update can land on the same edge, because the two monitors share only the clock. The bench provokes this from reset. It holds both rails high and opens a window of exactly LOS_RUN cycles containing one decoded zero. The window closes on the edge that sets the loss flag, and both flags are judged together after that edge against expected values of 1. The sweeps that surround this case cover space runs of 0 to 14 with each mark rail, and every zero count in windows of one to six cycles. An arithmetic per-edge model in the bench computes the expected outputs.

// File: rtl/la_pkg.sv
package la_pkg;

    typedef struct packed {
        logic a_n;
        logic b_n;
    } rail_pair_t;

    typedef enum logic {
        WIN_LOW  = 1'b0,
        WIN_HIGH = 1'b1
    } win_level_t;

    // A mark exists when either active-low rail is pulled down.
    function automatic logic rail_is_mark(rail_pair_t r);
        return !(r.a_n && r.b_n);
    endfunction

endpackage

// File: rtl/la_space_run.sv
module la_space_run #(
    parameter int LOS_RUN = 11
) (
    input  logic clk,
    input  logic rst,
    input  logic mark,
    output logic los
);
    localparam int W = $clog2(LOS_RUN + 1);
    localparam logic [W-1:0] LIMIT = W'(LOS_RUN);

    logic [W-1:0] run_q;
    logic         at_limit;

    assign at_limit = (run_q == LIMIT);

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= '0;
            los   <= 1'b0;
        end else begin
            los <= at_limit;
            if (mark)
                run_q <= '0;
            else if (!at_limit)
                run_q <= run_q + 1'b1;
        end
    end
endmodule

// File: rtl/la_zero_window.sv
module la_zero_window
    import la_pkg::*;
#(
    parameter int AIS_MIN = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic nrz_bit,
    input  logic win_n,
    output logic ais
);
    localparam int W = $clog2(AIS_MIN + 1);
    localparam logic [W-1:0] LIMIT = W'(AIS_MIN);

    logic [W-1:0] zero_q;
    win_level_t   prev_q;
    logic         closing;

    assign closing = (win_n == 1'b0) && (prev_q == WIN_HIGH);

    always_ff @(posedge clk) begin
        if (rst) begin
            zero_q <= '0;
            prev_q <= WIN_LOW;
            ais    <= 1'b0;
        end else begin
            prev_q <= win_n ? WIN_HIGH : WIN_LOW;
            if (closing)
                ais <= (zero_q < LIMIT);
            if (!win_n)
                zero_q <= '0;
            else if (!nrz_bit && (zero_q != LIMIT))
                zero_q <= zero_q + 1'b1;
        end
    end
endmodule

// File: rtl/line_alarm_mon.sv
module line_alarm_mon
    import la_pkg::*;
#(
    parameter int LOS_RUN = 11,
    parameter int AIS_MIN = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic rail_a_n,
    input  logic rail_b_n,
    input  logic nrz_bit,
    input  logic win_n,
    output logic los_flag,
    output logic ais_flag
);
    rail_pair_t rails;
    logic       mark;

    assign rails = '{a_n: rail_a_n, b_n: rail_b_n};
    assign mark  = rail_is_mark(rails);

    la_space_run #(.LOS_RUN(LOS_RUN)) run_i (
        .clk  (clk),
        .rst  (rst),
        .mark (mark),
        .los  (los_flag)
    );

    la_zero_window #(.AIS_MIN(AIS_MIN)) win_i (
        .clk     (clk),
        .rst     (rst),
        .nrz_bit (nrz_bit),
        .win_n   (win_n),
        .ais     (ais_flag)
    );
endmodule

// File: rtl/line_alarm_mon_chk.sv
module line_alarm_mon_chk (
    input logic clk,
    input logic rst,
    input logic rail_a_n,
    input logic rail_b_n,
    input logic win_n,
    input logic los_flag,
    input logic ais_flag
);
    logic space;
    assign space = rail_a_n && rail_b_n;

    // R3: a mark clears the alarm two samples later
    a_r3_mark_clears: assert property (@(posedge clk) disable iff (rst)
        !space |-> ##2 !los_flag);

    // R2: the alarm can only rise after a space
    a_r2_rise_after_space: assert property (@(posedge clk) disable iff (rst)
        $rose(los_flag) |-> $past(space, 2));

    // R4: alarm persists while spaces continue
    a_r4_los_hold: assert property (@(posedge clk) disable iff (rst)
        (los_flag && $past(space)) |=> los_flag);

    // R7: AIS only moves on a window close
    a_r7_ais_hold: assert property (@(posedge clk) disable iff (rst)
        !(!win_n && $past(win_n)) |=> $stable(ais_flag));

    // R9: reset clears both alarms
    a_r9_reset_clear: assert property (@(posedge clk)
        rst |=> (!los_flag && !ais_flag));
endmodule

bind line_alarm_mon line_alarm_mon_chk chk_i (
    .clk      (clk),
    .rst      (rst),
    .rail_a_n (rail_a_n),
    .rail_b_n (rail_b_n),
    .win_n    (win_n),
    .los_flag (los_flag),
    .ais_flag (ais_flag)
);

// File: tb/line_alarm_mon_tb.sv
module line_alarm_mon_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int RUN = 11;
    localparam int MIN = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rail_a_n = 1'b1, rail_b_n = 1'b1, nrz_bit = 1'b1, win_n = 1'b0;
    logic los_flag, ais_flag;

    int n_vec = 0, n_bad = 0;
    // bench model state
    int  m_run = 0, m_zero = 0;
    logic m_prev = 1'b0, m_los = 1'b0, m_ais = 1'b0;

    line_alarm_mon #(.LOS_RUN(RUN), .AIS_MIN(MIN)) dut_i (
        .clk(clk), .rst(rst), .rail_a_n(rail_a_n), .rail_b_n(rail_b_n),
        .nrz_bit(nrz_bit), .win_n(win_n), .los_flag(los_flag), .ais_flag(ais_flag));

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(string req, logic act, logic exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    // advance one edge with the current inputs and update the model
    task automatic tick();
        logic mk;
        mk = !(rail_a_n && rail_b_n);
        @(posedge clk);
        #1;
        if (rst) begin
            m_run = 0; m_zero = 0; m_prev = 0; m_los = 0; m_ais = 0;
        end else begin
            m_los = (m_run >= RUN);
            m_run = mk ? 0 : (m_run < 1000 ? m_run + 1 : m_run);
            if (!win_n && m_prev) m_ais = (m_zero < MIN);
            m_zero = win_n ? m_zero + (nrz_bit ? 0 : 1) : 0;
            m_prev = win_n;
        end
    endtask

    task automatic tick_chk(string tag);
        tick();
        check({tag, " los"}, los_flag, m_los);
        check({tag, " ais"}, ais_flag, m_ais);
    endtask

    task automatic set_mark(int kind);
        rail_a_n = (kind == 1) ? 1'b1 : 1'b0;
        rail_b_n = (kind == 0) ? 1'b1 : 1'b0;
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 50000);
        n_bad++;
        $display("FAIL watchdog: got hang expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        // R9 reset state
        repeat (3) tick_chk("R9");
        rst = 1'b0;

        // Combined: los rise and AIS close on the same edge (R2 R6)
        rail_a_n = 1'b1; rail_b_n = 1'b1; win_n = 1'b1;
        for (int i = 1; i <= RUN; i++) begin
            nrz_bit = (i == 1) ? 1'b0 : 1'b1;
            tick_chk("R2 R5");
        end
        check("R2 before limit", los_flag, 1'b0);
        win_n = 1'b0;
        tick_chk("R2 R6 same-edge");
        check("R2 same-edge los", los_flag, 1'b1);
        check("R6 same-edge ais", ais_flag, 1'b1);
        repeat (5) tick_chk("R4");
        check("R4 held", los_flag, 1'b1);

        // R1 R2 R3 R4: run lengths 0..14 ended by each mark rail
        for (int n = 0; n <= 14; n++) begin
            set_mark(n % 3);
            tick_chk("R1 R3");
            rail_a_n = 1'b1; rail_b_n = 1'b1;
            for (int i = 0; i < n; i++) tick_chk("R2 R4");
            set_mark((n + 1) % 3);
            tick_chk("R3");
            tick_chk("R3");
            check("R3 cleared", los_flag, 1'b0);
            if (n == RUN - 1) check("R2 ten spaces", los_flag, 1'b0);
        end

        // R5 R6 R7: every zero count in windows of 1..6
        set_mark(2);
        for (int len = 1; len <= 6; len++) begin
            for (int z = 0; z <= len; z++) begin
                win_n = 1'b1;
                for (int i = 0; i < len; i++) begin
                    nrz_bit = ((len + z) % 2 == 0) ? (i >= z) : (i < len - z);
                    tick_chk("R5 R7");
                end
                win_n = 1'b0; nrz_bit = 1'b0;
                tick_chk("R6");
                check("R6 threshold", ais_flag, (z < MIN));
                tick_chk("R7 R5");
            end
        end

        // R8: long window saturates
        win_n = 1'b1; nrz_bit = 1'b0;
        repeat (20) tick_chk("R8");
        win_n = 1'b0;
        tick_chk("R8");
        check("R8 long window", ais_flag, 1'b0);
        win_n = 1'b1; nrz_bit = 1'b1;
        tick_chk("R8");
        win_n = 1'b0;
        tick_chk("R6");
        check("R6 empty window", ais_flag, 1'b1);

        // R9: reset from alarmed state, then low period without window
        rail_a_n = 1'b1; rail_b_n = 1'b1;
        repeat (RUN + 2) tick_chk("R4");
        check("R9 pre los", los_flag, 1'b1);
        rst = 1'b1;
        tick_chk("R9");
        check("R9 los cleared", los_flag, 1'b0);
        check("R9 ais cleared", ais_flag, 1'b0);
        rst = 1'b0; set_mark(0); win_n = 1'b0;
        repeat (3) tick_chk("R9");
        check("R9 no update", ais_flag, 1'b0);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule